// File: doc/BRIEF.md
# Streaming 3x3 Image Convolution Filter

This block filters a raster-ordered stream of grayscale pixels with a fixed 3x3 kernel. One pixel arrives per cycle in which `in_valid` is high. Two line delays, each as deep as the line width, hold the two lines above the newest pixel. Together with a three-column shift register they form a 3x3 neighbourhood that moves one step for every accepted pixel. Nine multipliers, each with a constant coefficient, weight the neighbourhood. A three-stage adder tree sums the products at full precision. The fractional bits are dropped only when the result is registered onto the output.

Coefficients are unsigned fixed-point numbers whose bits are all fractional, so each one is below one. They are set at elaboration. The default is the 1-2-1 / 2-4-2 / 1-2-1 smoothing kernel scaled by 1/16. A start-of-frame strobe restarts the column position and the fill count. The line memories keep their contents across frames, and the fill rule hides those stale contents. Pixels in the first two columns of a line see a window that wraps onto the end of the previous line. Such pixels are still delivered as valid.

Top module: `conv3x3_stream`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0. `out_pix` reads 0 after reset.
- R2: An accepted pixel that completes a window gives exactly one output, with `out_valid` high seven cycles after the cycle in which the pixel was presented. `out_valid` is never high at any other time.
- R3: The first 2*LINE_W+2 pixels accepted after reset or after a start of frame produce no output.
- R4: Number the pixels of a frame n = 0, 1, 2, ... in arrival order. The window of pixel n has tap t = 3*r + c (r, c in 0..2), which holds pixel n - (2-r)*LINE_W - (2-c). So r = 0 is the oldest line and c = 0 is the oldest column. Coefficient t occupies bits [8t+7:8t] of `KERNEL`.
- R5: Pixels in column 0 or 1 of a line (n mod LINE_W < 2) are still valid outputs. Their windows follow the same index rule, so they reach back into the previous line.
- R6: The output is floor(S / 256) mod 256, where S is the exact unsigned sum of the nine 8-bit pixel and 8-bit coefficient products. No rounding and no saturation are applied.
- R7: By default the kernel is 16 at the four corners, 32 on the four edges and 64 at the centre. A flat field of value v therefore returns v.
- R8: Cycles with `in_valid` low do not move the window or the fill count, and `in_pix` is ignored in those cycles. Gaps in the stream leave the results unchanged.
- R9: If `sof` is high together with `in_valid`, that pixel becomes pixel 0 of a new frame. If `sof` is high alone, the next accepted pixel is pixel 0. Outputs already in the pipeline still emerge.
- R10: `out_pix` keeps its last value while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start of frame: restarts column and fill count |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | PIX_W | Input pixel |
| out_valid | output | 1 | Filtered pixel strobe |
| out_pix | output | PIX_W | Filtered pixel |

## Verification
Each result is due exactly seven cycles after the cycle in which its newest pixel was presented. The bench drives on the falling edge. When it drives a pixel that completes a window, it computes the expected value from the index rule and the arithmetic above. It files that value in a 16-slot ring under the cycle number plus seven. On every falling edge it compares both outputs against the slot for the current cycle. An empty slot means no output is allowed and `out_pix` must hold. Two instances run side by side: one with the default kernel and one with an asymmetric kernel, so that a swapped tap order is detected.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  localparam int TAPS    = 9;
  localparam int KSIDE   = 3;
  localparam int LAT     = 7;
  localparam int Q8_W    = 8;
  // smoothing kernel, Q0.8, tap t = 3*row + col at bits [8t+7:8t]
  localparam logic [TAPS*Q8_W-1:0] SMOOTH_Q8 = {
    8'd16, 8'd32, 8'd16,
    8'd32, 8'd64, 8'd32,
    8'd16, 8'd32, 8'd16
  };
  function automatic int fill_len(input int line_w);
    return 2 * line_w + 2;
  endfunction
endpackage

// File: rtl/conv3_linebuf.sv
module conv3_linebuf #(
  parameter int DEPTH = 640,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // single port, read-before-write: returns the word stored DEPTH writes ago
  always_ff @(posedge clk) begin
    if (en) begin
      rdata      <= mem[addr];
      mem[addr]  <= wdata;
    end
  end
endmodule

// File: rtl/conv3_window.sv
module conv3_window import conv3_pkg::*; #(
  parameter int LINE_W = 640,
  parameter int PIX_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sof,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        in_pix,
  output logic                    win_valid,
  output logic [TAPS*PIX_W-1:0]   win_pix
);
  localparam int AW   = (LINE_W > 1) ? $clog2(LINE_W) : 1;
  localparam int FILL = fill_len(LINE_W);
  localparam int CW   = $clog2(FILL + 1);

  logic [AW-1:0]    col_q, addr0, addr1;
  logic [CW-1:0]    cnt_q, idx0;
  logic             tag0, tag1, tag2;
  logic             v1, v2;
  logic [PIX_W-1:0] p1, p2, a2, q1, q2;
  logic [KSIDE*PIX_W-1:0] col_new;
  logic [TAPS*PIX_W-1:0]  win_q;
  logic             wv_q;

  assign addr0 = sof ? '0 : col_q;
  assign idx0  = sof ? '0 : cnt_q;
  assign tag0  = (idx0 == CW'(FILL));

  // column position and saturating fill count
  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      cnt_q <= '0;
    end else if (in_valid) begin
      col_q <= (addr0 == AW'(LINE_W - 1)) ? '0 : addr0 + AW'(1);
      cnt_q <= tag0 ? idx0 : idx0 + CW'(1);
    end else if (sof) begin
      col_q <= '0;
      cnt_q <= '0;
    end
  end

  // first line delay, fed by the live stream
  conv3_linebuf #(.DEPTH(LINE_W), .W(PIX_W)) u_lb_near (
    .clk   (clk),
    .en    (in_valid),
    .addr  (addr0),
    .wdata (in_pix),
    .rdata (q1)
  );

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
  end
  always_ff @(posedge clk) begin
    tag1  <= tag0;
    p1    <= in_pix;
    addr1 <= addr0;
  end

  // second line delay, fed by the output of the first one stage later
  conv3_linebuf #(.DEPTH(LINE_W), .W(PIX_W)) u_lb_far (
    .clk   (clk),
    .en    (v1),
    .addr  (addr1),
    .wdata (q1),
    .rdata (q2)
  );

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
  end
  always_ff @(posedge clk) begin
    tag2 <= tag1;
    p2   <= p1;
    a2   <= q1;
  end

  // newest column: oldest line in the low slot
  assign col_new = {p2, a2, q2};

  always_ff @(posedge clk) begin
    if (v2) begin
      for (int r = 0; r < KSIDE; r++) begin
        for (int c = 0; c < KSIDE - 1; c++) begin
          win_q[(KSIDE*r+c)*PIX_W +: PIX_W] <= win_q[(KSIDE*r+c+1)*PIX_W +: PIX_W];
        end
        win_q[(KSIDE*r+KSIDE-1)*PIX_W +: PIX_W] <= col_new[r*PIX_W +: PIX_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wv_q <= 1'b0;
    else     wv_q <= v2 & tag2;
  end

  assign win_valid = wv_q;
  assign win_pix   = win_q;
endmodule

// File: rtl/conv3_mac.sv
module conv3_mac import conv3_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter logic [TAPS*COEF_W-1:0] KERNEL = SMOOTH_Q8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [TAPS*PIX_W-1:0] in_win,
  output logic                  out_valid,
  output logic [PIX_W-1:0]      out_pix
);
  localparam int PROD_W = PIX_W + COEF_W;
  localparam int ROW_W  = PROD_W + 2;
  localparam int SUM_W  = PROD_W + 4;
  localparam int FRAC   = COEF_W;

  logic [PROD_W-1:0] prod_q [TAPS];
  logic [ROW_W-1:0]  row_q  [KSIDE];
  logic [SUM_W-1:0]  pair_q, odd_q, total;
  logic              pv, rv, sv;

  // constant-coefficient multipliers
  always_ff @(posedge clk) begin
    for (int t = 0; t < TAPS; t++) begin
      prod_q[t] <= PROD_W'(in_win[t*PIX_W +: PIX_W]) * PROD_W'(KERNEL[t*COEF_W +: COEF_W]);
    end
  end

  // adder stage 1: one three-input adder per kernel row
  genvar r;
  generate
    for (r = 0; r < KSIDE; r++) begin : g_row
      always_ff @(posedge clk) begin
        row_q[r] <= ROW_W'(prod_q[KSIDE*r]) + ROW_W'(prod_q[KSIDE*r+1])
                  + ROW_W'(prod_q[KSIDE*r+2]);
      end
    end
  endgenerate

  // adder stage 2: two rows combined, third carried
  always_ff @(posedge clk) begin
    pair_q <= SUM_W'(row_q[0]) + SUM_W'(row_q[1]);
    odd_q  <= SUM_W'(row_q[2]);
  end

  // adder stage 3 with the only truncation
  assign total = pair_q + odd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= 1'b0;
      rv <= 1'b0;
      sv <= 1'b0;
    end else begin
      pv <= in_valid;
      rv <= pv;
      sv <= rv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= sv;
      if (sv) out_pix <= total[FRAC +: PIX_W];
    end
  end
endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream import conv3_pkg::*; #(
  parameter int LINE_W = 640,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter logic [TAPS*COEF_W-1:0] KERNEL = SMOOTH_Q8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  logic                  win_valid;
  logic [TAPS*PIX_W-1:0] win_pix;

  conv3_window #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .sof       (sof),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .win_valid (win_valid),
    .win_pix   (win_pix)
  );

  conv3_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .KERNEL(KERNEL)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (win_valid),
    .in_win    (win_pix),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );
endmodule

// File: rtl/conv3_checker.sv
module conv3_checker import conv3_pkg::*; #(
  parameter int LINE_W = 640,
  parameter int PIX_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sof,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_pix,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  localparam int FILL = fill_len(LINE_W);
  int seen;
  logic unused_pix;
  assign unused_pix = ^in_pix;

  always_ff @(posedge clk) begin
    if (rst) seen <= 0;
    else if (in_valid) seen <= sof ? 1 : ((seen < FILL) ? seen + 1 : seen);
    else if (sof) seen <= 0;
  end

  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);  // R1
  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 7));  // R2
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (sof || seen < FILL)) |-> ##7 !out_valid);  // R3
  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_pix));  // R10
endmodule

bind conv3x3_stream conv3_checker #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sof       (sof),
  .in_valid  (in_valid),
  .in_pix    (in_pix),
  .out_valid (out_valid),
  .out_pix   (out_pix)
);

// File: tb/sim_conv3x3_stream.sv
`timescale 1ns/1ps
module sim_conv3x3_stream;
  localparam int W    = 8;
  localparam int LAT  = 7;
  localparam int FILL = 2 * W + 2;
  localparam logic [71:0] KASYM = {8'd120, 8'd9, 8'd5, 8'd63, 8'd31, 8'd15, 8'd7, 8'd3, 8'd1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sof = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_pix = 8'd0;
  logic ov0, ov1;
  logic [7:0] op0, op1;

  always #2.5 clk = ~clk;

  conv3x3_stream #(.LINE_W(W)) u0 (
    .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(ov0), .out_pix(op0));

  conv3x3_stream #(.LINE_W(W), .KERNEL(KASYM)) u1 (
    .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(ov1), .out_pix(op1));

  int n_chk = 0;
  int n_fail = 0;
  int hist [0:255];
  int nidx = 0;
  int cy = 0;
  bit ev [2][16];
  int ep [2][16];
  string et [2][16];
  int hold [2];
  string ph = "R4";
  bit done = 1'b0;

  function automatic int kcoef(input int inst, input int t);
    int r, c, dr, dc;
    r = t / 3; c = t % 3;
    dr = (r == 1) ? 0 : 1;
    dc = (c == 1) ? 0 : 1;
    if (inst == 0) return 16 << (2 - dr - dc);  // R7
    return int'(KASYM[t*8 +: 8]);
  endfunction

  function automatic int model(input int inst, input int n);
    int s = 0;
    for (int t = 0; t < 9; t++) begin
      s += hist[n - (2 - t/3) * W - (2 - t%3)] * kcoef(inst, t);  // R4
    end
    return (s >> 8) & 255;  // R6
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cy);
    end
  endtask

  task automatic step(input bit v, input bit s, input int p);
    int slot, idx, av, apx;
    @(negedge clk);
    cy++;
    slot = cy % 16;
    for (int i = 0; i < 2; i++) begin
      av  = (i == 0) ? int'(ov0) : int'(ov1);
      apx = (i == 0) ? int'(op0) : int'(op1);
      if (ev[i][slot]) begin
        chk(av == 1, "R2", $sformatf("u%0d out_valid", i), av, 1);
        chk(apx == ep[i][slot], et[i][slot], $sformatf("u%0d out_pix", i), apx, ep[i][slot]);
        hold[i] = ep[i][slot];
      end else begin
        chk(av == 0, rst ? "R1" : "R3", $sformatf("u%0d out_valid", i), av, 0);
        chk(apx == hold[i], "R10", $sformatf("u%0d out_pix hold", i), apx, hold[i]);
      end
      ev[i][slot] = 1'b0;
    end
    in_valid = v;
    sof      = s;
    in_pix   = 8'(p);
    if (v) begin
      idx = s ? 0 : nidx;
      hist[idx] = p;
      nidx = idx + 1;
      if (idx >= FILL) begin
        for (int i = 0; i < 2; i++) begin
          ev[i][(cy + LAT) % 16] = 1'b1;
          ep[i][(cy + LAT) % 16] = model(i, idx);
          et[i][(cy + LAT) % 16] = ((idx % W) < 2) ? "R5" : ((i == 1) ? "R6" : ph);
        end
      end
    end else if (s) begin
      nidx = 0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    hold[0] = 0; hold[1] = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) step(0, 0, 0);
    chk(ov0 == 0 && op0 == 0, "R1", "u0 reset state", int'(op0), 0);
    chk(ov1 == 0 && op1 == 0, "R1", "u1 reset state", int'(op1), 0);
    rst = 1'b0;
    step(0, 0, 0);
    // R4: continuous random frame
    ph = "R4";
    for (int k = 0; k < 6 * W; k++) step(1, k == 0, int'($urandom % 256));
    for (int k = 0; k < 10; k++) step(0, 0, int'($urandom % 256));
    // R8: random gaps, junk pixels while idle
    ph = "R8";
    step(1, 1, int'($urandom % 256));
    for (int k = 0; k < 90; k++) begin
      if (($urandom % 10) < 6) step(1, 0, int'($urandom % 256));
      else step(0, 0, int'($urandom % 256));
    end
    // R7: sof on its own, then a flat white field
    ph = "R7";
    step(0, 1, 0);
    for (int k = 0; k < 5 * W; k++) step(1, 0, 255);
    // R9: restart mid-line while outputs are in flight
    ph = "R9";
    step(1, 1, int'($urandom % 256));
    for (int k = 0; k < 12; k++) step(1, 0, int'($urandom % 256));
    step(1, 1, int'($urandom % 256));
    for (int k = 0; k < 40; k++) step(1, 0, int'($urandom % 256));
    // R6: extreme checkerboard values
    ph = "R6";
    step(1, 1, 0);
    for (int k = 1; k < 4 * W; k++) step(1, 0, ((k + k / W) % 2) ? 255 : 0);
    for (int k = 0; k < 12; k++) step(0, 0, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule